// File: doc/BRIEF.md
# Isolation group freeze filter

This block sits in the transaction path of a host bridge. It holds a freeze state for up to 256 isolation groups. Each group has two frozen bits: one covers outbound MMIO traffic and one covers inbound DMA and MSI traffic. For every transaction it is handed a group number and a transaction kind. One cycle later it returns a verdict: pass the transaction, drop it silently, or complete it with all-ones data.

Error logic raises a freeze for a group. The freeze sets both bits of that group in one step. Each bit is then thawed through its own clear port, so DMA can be restored while MMIO stays fenced, or the other way round. A capture register records the group and the error code of the first freeze after it was last cleared. This shows which group tripped first when several freezes follow one another.

Top module: `iso_frz_filter`

## Requirements
- R1: After reset no group is frozen, `rsp_valid_o` is 0 and `cap_valid_o` is 0.
- R2: A freeze (`frz_valid_i` with `frz_group_i`) sets both the MMIO and DMA bits of that group at the clock edge where it is sampled; requests presented from the next cycle onward see the group frozen.
- R3: `clr_mmio_valid_i` clears only the MMIO bit of `clr_mmio_group_i` and `clr_dma_valid_i` clears only the DMA bit of `clr_dma_group_i`; the other bit keeps its value.
- R4: If a freeze and a clear address the same group in the same cycle, the freeze wins and both bits end set.
- R5: Kind codes 0 (MMIO load) and 1 (MMIO store) are gated by the MMIO bit: while it is set, a load gets action 2 (all-ones completion) and a store gets action 1 (drop).
- R6: Kind codes 2 (DMA read), 3 (DMA write) and 4 (MSI) are gated by the DMA bit: while it is set, a DMA read gets action 2, and a DMA write or an MSI gets action 1.
- R7: Action 0 (pass) is returned when the gating bit is clear, and always for the unused kind codes 5 to 7.
- R8: The capture register latches the group and the 4-bit code of a freeze when it is empty and then ignores later freezes; `cap_clear_i` empties it, and a freeze in the same cycle as `cap_clear_i` is latched as the new first freeze.
- R9: The verdict is registered: `rsp_valid_o` and `rsp_action_o` reflect the request of the previous cycle, judged against the state held before that cycle's freezes and clears; `rsp_action_o` is 0 whenever `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transaction to judge this cycle |
| req_group_i | input | 8 | Isolation group of the transaction |
| req_kind_i | input | 3 | Kind: 0 MMIO load, 1 MMIO store, 2 DMA read, 3 DMA write, 4 MSI |
| rsp_valid_o | output | 1 | Verdict valid, one cycle after the request |
| rsp_action_o | output | 2 | 0 pass, 1 drop, 2 complete with all ones |
| frz_valid_i | input | 1 | Freeze a group |
| frz_group_i | input | 8 | Group to freeze |
| frz_code_i | input | 4 | Error code offered to the capture register |
| clr_mmio_valid_i | input | 1 | Clear the MMIO bit of a group |
| clr_mmio_group_i | input | 8 | Group whose MMIO bit is cleared |
| clr_dma_valid_i | input | 1 | Clear the DMA bit of a group |
| clr_dma_group_i | input | 8 | Group whose DMA bit is cleared |
| cap_clear_i | input | 1 | Empty the capture register |
| cap_valid_o | output | 1 | Capture register holds a freeze |
| cap_group_o | output | 8 | Group of the first captured freeze |
| cap_code_o | output | 4 | Code of the first captured freeze |

## Verification
The assertions check on every cycle that a freeze leaves both bits of its group set, even when a clear hits that group in the same cycle. They also check that a lone clear drops only its own bit, that a held capture stays stable, and that each request yields a verdict one cycle later, with pass whenever the group is thawed. Only the bench scenarios show the full mapping from kind and bit to action. These include the partial-thaw cases where MMIO loads pass while DMA reads still return all ones, and the rule that a request coinciding with a freeze is judged on the older state. The random phase checks every verdict and the capture contents against a bench model over mixed freezes, clears and capture clears.

// File: rtl/iso_frz_pkg.sv
package iso_frz_pkg;
  typedef enum logic [2:0] {
    KIND_MMIO_LD = 3'd0,
    KIND_MMIO_ST = 3'd1,
    KIND_DMA_RD  = 3'd2,
    KIND_DMA_WR  = 3'd3,
    KIND_MSI     = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_DROP = 2'd1,
    ACT_ONES = 2'd2
  } act_e;
endpackage

// File: rtl/iso_frz_state.sv
module iso_frz_state #(
  parameter int GROUPS = 256,
  localparam int GW = $clog2(GROUPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frz_i,
  input  logic [GW-1:0] frz_grp_i,
  input  logic          clr_mmio_i,
  input  logic [GW-1:0] clr_mmio_grp_i,
  input  logic          clr_dma_i,
  input  logic [GW-1:0] clr_dma_grp_i,
  input  logic [GW-1:0] lk_grp_i,
  output logic          lk_mmio_o,
  output logic          lk_dma_o
);
  logic [GROUPS-1:0] mmio_q, dma_q;

  // clear first, freeze last: freeze wins on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mmio_q <= '0;
      dma_q  <= '0;
    end else begin
      if (clr_mmio_i) mmio_q[clr_mmio_grp_i] <= 1'b0;
      if (clr_dma_i)  dma_q[clr_dma_grp_i]   <= 1'b0;
      if (frz_i) begin
        mmio_q[frz_grp_i] <= 1'b1;
        dma_q[frz_grp_i]  <= 1'b1;
      end
    end
  end

  assign lk_mmio_o = mmio_q[lk_grp_i];
  assign lk_dma_o  = dma_q[lk_grp_i];

  AST_FREEZE_SETS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_i |=> mmio_q[$past(frz_grp_i)] && dma_q[$past(frz_grp_i)]); // R2 R4

  AST_CLR_MMIO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_mmio_i && !(frz_i && frz_grp_i == clr_mmio_grp_i)
      && !(clr_dma_i && clr_dma_grp_i == clr_mmio_grp_i)
    |=> !mmio_q[$past(clr_mmio_grp_i)]
      && dma_q[$past(clr_mmio_grp_i)] == $past(dma_q[clr_mmio_grp_i])); // R3

  AST_CLR_DMA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dma_i && !(frz_i && frz_grp_i == clr_dma_grp_i)
      && !(clr_mmio_i && clr_mmio_grp_i == clr_dma_grp_i)
    |=> !dma_q[$past(clr_dma_grp_i)]
      && mmio_q[$past(clr_dma_grp_i)] == $past(mmio_q[clr_dma_grp_i])); // R3
endmodule

// File: rtl/iso_frz_capture.sv
module iso_frz_capture #(
  parameter int GW = 8,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frz_i,
  input  logic [GW-1:0] frz_grp_i,
  input  logic [CW-1:0] frz_code_i,
  input  logic          clear_i,
  output logic          valid_o,
  output logic [GW-1:0] grp_o,
  output logic [CW-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      grp_o   <= '0;
      code_o  <= '0;
    end else if (frz_i && (!valid_o || clear_i)) begin
      valid_o <= 1'b1;
      grp_o   <= frz_grp_i;
      code_o  <= frz_code_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !clear_i |=> valid_o && $stable(grp_o) && $stable(code_o)); // R8

  AST_CAP_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_i && (!valid_o || clear_i)
    |=> valid_o && grp_o == $past(frz_grp_i) && code_o == $past(frz_code_i)); // R8

  AST_CAP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !frz_i |=> !valid_o); // R8
endmodule

// File: rtl/iso_frz_decide.sv
module iso_frz_decide
  import iso_frz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_kind_i,
  input  logic       mmio_frz_i,
  input  logic       dma_frz_i,
  output logic       rsp_valid_o,
  output logic [1:0] rsp_action_o
);
  act_e act_d;

  always_comb begin
    act_d = ACT_PASS;
    if (req_valid_i) begin
      unique case (req_kind_i)
        KIND_MMIO_LD: if (mmio_frz_i) act_d = ACT_ONES;
        KIND_MMIO_ST: if (mmio_frz_i) act_d = ACT_DROP;
        KIND_DMA_RD:  if (dma_frz_i)  act_d = ACT_ONES;
        KIND_DMA_WR,
        KIND_MSI:     if (dma_frz_i)  act_d = ACT_DROP;
        default:      act_d = ACT_PASS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_action_o <= ACT_PASS;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_action_o <= act_d;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R9

  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> rsp_action_o == ACT_PASS); // R9

  AST_THAW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !mmio_frz_i && !dma_frz_i |=> rsp_action_o == ACT_PASS); // R7
endmodule

// File: rtl/iso_frz_filter.sv
module iso_frz_filter #(
  parameter int GROUPS = 256,
  parameter int CODE_W = 4,
  localparam int GW = $clog2(GROUPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [GW-1:0]     req_group_i,
  input  logic [2:0]        req_kind_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_action_o,
  input  logic              frz_valid_i,
  input  logic [GW-1:0]     frz_group_i,
  input  logic [CODE_W-1:0] frz_code_i,
  input  logic              clr_mmio_valid_i,
  input  logic [GW-1:0]     clr_mmio_group_i,
  input  logic              clr_dma_valid_i,
  input  logic [GW-1:0]     clr_dma_group_i,
  input  logic              cap_clear_i,
  output logic              cap_valid_o,
  output logic [GW-1:0]     cap_group_o,
  output logic [CODE_W-1:0] cap_code_o
);
  logic lk_mmio, lk_dma;

  iso_frz_state #(.GROUPS(GROUPS)) u_state (
    .clk_i, .rst_ni,
    .frz_i          (frz_valid_i),
    .frz_grp_i      (frz_group_i),
    .clr_mmio_i     (clr_mmio_valid_i),
    .clr_mmio_grp_i (clr_mmio_group_i),
    .clr_dma_i      (clr_dma_valid_i),
    .clr_dma_grp_i  (clr_dma_group_i),
    .lk_grp_i       (req_group_i),
    .lk_mmio_o      (lk_mmio),
    .lk_dma_o       (lk_dma)
  );

  iso_frz_decide u_decide (
    .clk_i, .rst_ni,
    .req_valid_i,
    .req_kind_i,
    .mmio_frz_i   (lk_mmio),
    .dma_frz_i    (lk_dma),
    .rsp_valid_o,
    .rsp_action_o
  );

  iso_frz_capture #(.GW(GW), .CW(CODE_W)) u_cap (
    .clk_i, .rst_ni,
    .frz_i      (frz_valid_i),
    .frz_grp_i  (frz_group_i),
    .frz_code_i (frz_code_i),
    .clear_i    (cap_clear_i),
    .valid_o    (cap_valid_o),
    .grp_o      (cap_group_o),
    .code_o     (cap_code_o)
  );
endmodule

// File: tb/iso_frz_filter_tb.sv
`timescale 1ns/1ps
module iso_frz_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_v = 0, frz_v = 0, cm_v = 0, cd_v = 0, cap_clr = 0;
  logic [7:0] req_g = 0, frz_g = 0, cm_g = 0, cd_g = 0;
  logic [2:0] req_k = 0;
  logic [3:0] frz_c = 0;
  logic       rsp_v, cap_v;
  logic [1:0] rsp_a;
  logic [7:0] cap_g;
  logic [3:0] cap_c;

  int total = 0, bad = 0;
  bit done = 0;
  bit m_mm [256];
  bit m_dm [256];
  bit e_cv;
  logic [7:0] e_cg;
  logic [3:0] e_cc;

  always #2.5 clk = ~clk;

  iso_frz_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v), .req_group_i(req_g), .req_kind_i(req_k),
    .rsp_valid_o(rsp_v), .rsp_action_o(rsp_a),
    .frz_valid_i(frz_v), .frz_group_i(frz_g), .frz_code_i(frz_c),
    .clr_mmio_valid_i(cm_v), .clr_mmio_group_i(cm_g),
    .clr_dma_valid_i(cd_v), .clr_dma_group_i(cd_g),
    .cap_clear_i(cap_clr),
    .cap_valid_o(cap_v), .cap_group_o(cap_g), .cap_code_o(cap_c)
  );

  function automatic logic [1:0] exp_act(logic v, logic [2:0] k, logic [7:0] g);
    if (!v) return 2'd0;
    case (k)
      3'd0: return m_mm[g] ? 2'd2 : 2'd0;
      3'd1: return m_mm[g] ? 2'd1 : 2'd0;
      3'd2: return m_dm[g] ? 2'd2 : 2'd0;
      3'd3, 3'd4: return m_dm[g] ? 2'd1 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic rv, logic [2:0] rk, logic [7:0] rg,
                     logic fv, logic [7:0] fg, logic [3:0] fc,
                     logic mv, logic [7:0] mg, logic dv, logic [7:0] dg,
                     logic cc, string tag);
    logic [1:0] ea;
    @(negedge clk);
    req_v = rv; req_k = rk; req_g = rg;
    frz_v = fv; frz_g = fg; frz_c = fc;
    cm_v = mv; cm_g = mg; cd_v = dv; cd_g = dg; cap_clr = cc;
    ea = exp_act(rv, rk, rg);
    @(posedge clk); #1;
    if (mv) m_mm[mg] = 0;
    if (dv) m_dm[dg] = 0;
    if (fv) begin m_mm[fg] = 1; m_dm[fg] = 1; end
    if (fv && (!e_cv || cc)) begin e_cv = 1; e_cg = fg; e_cc = fc; end
    else if (cc) e_cv = 0;
    chk("R9 rsp_valid", rsp_v, rv);
    chk(tag, rsp_a, ea);
    chk("R8 cap_valid", cap_v, e_cv);
    if (e_cv) begin
      chk("R8 cap_group", cap_g, e_cg);
      chk("R8 cap_code", cap_c, e_cc);
    end
  endtask

  task automatic idle(); cyc(0,0,0, 0,0,0, 0,0,0,0, 0, "R9 idle"); endtask
  task automatic req(logic [2:0] k, logic [7:0] g, string tag);
    cyc(1,k,g, 0,0,0, 0,0,0,0, 0, tag);
  endtask

  initial begin
    #500us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51ed_0c0d));
    e_cv = 0; e_cg = 0; e_cc = 0;
    #12 rst_n = 1'b1;
    #1;
    chk("R1 rsp_valid", rsp_v, 0);
    chk("R1 cap_valid", cap_v, 0);
    for (int k = 0; k < 5; k++) req(k[2:0], 8'd255, "R1 thawed pass");
    req(3'd0, 8'd0, "R1 thawed pass");

    // freeze 255: both bits set at once
    cyc(1,3'd0,8'd255, 1,8'd255,4'hA, 0,0,0,0, 0, "R9 old state");
    req(3'd0, 8'd255, "R2 R5 mmio load ones");
    req(3'd1, 8'd255, "R2 R5 mmio store drop");
    req(3'd2, 8'd255, "R2 R6 dma read ones");
    req(3'd3, 8'd255, "R6 dma write drop");
    req(3'd4, 8'd255, "R6 msi blocked");
    req(3'd5, 8'd255, "R7 unused kind pass");
    req(3'd7, 8'd255, "R7 unused kind pass");
    req(3'd0, 8'd254, "R7 other group pass");

    // second freeze ignored by capture
    cyc(0,0,0, 1,8'd3,4'h5, 0,0,0,0, 0, "R8 ignore later");
    // clear MMIO of 255 only
    cyc(0,0,0, 0,0,0, 1,8'd255,0,0, 0, "R3 clr mmio");
    req(3'd0, 8'd255, "R3 mmio load passes");
    req(3'd2, 8'd255, "R3 dma read still ones");
    // clear DMA of 3 only
    cyc(0,0,0, 0,0,0, 0,0,1,8'd3, 0, "R3 clr dma");
    req(3'd4, 8'd3, "R3 msi passes");
    req(3'd1, 8'd3, "R3 mmio store still dropped");
    // freeze and clears on same group
    cyc(0,0,0, 1,8'd9,4'h1, 1,8'd9,1,8'd9, 0, "R4 collide");
    req(3'd0, 8'd9, "R4 freeze wins mmio");
    req(3'd3, 8'd9, "R4 freeze wins dma");
    // capture clear, then clear together with freeze
    cyc(0,0,0, 0,0,0, 0,0,0,0, 1, "R8 cap clear");
    cyc(0,0,0, 1,8'd20,4'h2, 0,0,0,0, 0, "R8 first after clear");
    cyc(0,0,0, 1,8'd21,4'h3, 0,0,0,0, 1, "R8 clear plus freeze");
    idle();

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] g, fg, mg, dg;
      logic [2:0] k;
      string tag;
      g  = ($urandom % 9 == 8) ? 8'd255 : 8'($urandom % 8);
      fg = ($urandom % 9 == 8) ? 8'd255 : 8'($urandom % 8);
      mg = 8'($urandom % 8);
      dg = 8'($urandom % 8);
      k  = 3'($urandom % 8);
      tag = (k < 2) ? "R5 random" : (k < 5) ? "R6 random" : "R7 random";
      cyc($urandom % 4 != 0, k, g,
          $urandom % 12 == 0, fg, 4'($urandom),
          $urandom % 5 == 0, mg, $urandom % 5 == 0, dg,
          $urandom % 20 == 0, tag);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule